// File: doc/BRIEF.md
# Parallel-Bus Bridge Driver Command Interface

This block is the slave-side control logic for a motor-bridge power stage that sits on a shared 4-bit microcontroller bus. The bus has a nibble-wide data path, an active-low select line, a read/write-not line and a mode line. Write commands become drive states for four half-bridges and one high-side switch. OUT1, OUT2 and OUT3 each pair with OUT4 to form a bridge, and only one of these bridges runs at a time. Each output is driven high, driven low, or left floating.

The select line does more than frame a transfer. While the block is selected for a write, its outputs follow the bus without waiting. The select line's rising edge stores the command, and the stored command keeps running after the bus is released. A select pulse held low past a cycle limit wipes the stored state. A release with every other line low puts the block in standby. In read mode the block drives one of four diagnostic pages onto the data lines. A page-select command chooses the page. All bus lines pass through a clock-domain synchronizer before any edge is detected.

Top module: `pbus_bridge_ctrl`

## Requirements
- R1: After reset, drv_en is 0 on all five outputs, bus_d_oe is 0 and standby is 0.
- R2: While selected in write mode (bus_sel_n=0, bus_rd_wn=0), the drive outputs follow the command on bus_mode/bus_d_in, and a change of the command while still selected changes the outputs.
- R3: With bus_mode=0, bits d[3:2] pick the bridge: 00 = OUT1, 01 = OUT2, 10 = OUT3, 11 = none. Bits d[1:0] pick the action: 00 = off, 01 = forward (OUTx high, OUT4 low), 10 = reverse (OUTx low, OUT4 high), 11 = brake (OUTx and OUT4 both low). Every half-bridge not named is floated. OUT5 keeps its setting. At most one of OUT1..OUT3 is ever enabled. Mode 0 with d=0000 is also the standby code (R9).
- R4: With bus_mode=1, d[3:2]=00 sets OUT5 high if d[0]=1 and floats it if d[0]=0. d[3:2]=01 stores d[1:0] as the diagnostic page. d[3:2]=1x has no effect. None of these codes touches the half-bridges.
- R5: The rising edge of bus_sel_n stores the command on the bus, and the outputs keep that state after deselection.
- R6: While bus_sel_n=1, changes on bus_mode, bus_d_in and bus_rd_wn have no effect on the drive outputs, and bus_d_oe stays 0.
- R7: While selected with bus_rd_wn=1, bus_d_oe=1 and bus_d_out shows the page. Bit 0 is always on the right. Page 0 = out_level[3:0]. Page 1 = {overvolt, ovc_hs, ovc_bridge, out_level[4]}. Page 2 = {000, overtemp}. Page 3 = 0000. The drive outputs do not change during a read.
- R8: If bus_sel_n stays low for CLR_CYC cycles, all outputs float, the stored command and the page are cleared, and bus_d_oe is 0. Bus activity is then ignored, including the next rising edge, until a new falling edge of bus_sel_n.
- R9: A rising edge of bus_sel_n with bus_rd_wn, bus_mode and bus_d_in all low sets standby=1, clears the stored state and floats all outputs. A rising edge with bus_rd_wn high does not.
- R10: A falling edge of bus_sel_n clears standby. The stored state remains cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Active-low select from the bus |
| bus_rd_wn | input | 1 | 1 = read diagnostics, 0 = write command |
| bus_mode | input | 1 | Command class: 0 = bridge, 1 = high-side/page |
| bus_d_in | input | 4 | Data nibble from the bus pads |
| bus_d_out | output | 4 | Diagnostic nibble to the bus pads |
| bus_d_oe | output | 1 | Pad output enable for the data nibble |
| out_level | input | 5 | Output voltage high flags, OUT1 at bit 0 |
| ovc_bridge | input | 1 | Overcurrent flag of any half-bridge |
| ovc_hs | input | 1 | Overcurrent flag of the high-side switch |
| overvolt | input | 1 | Supply overvoltage flag |
| overtemp | input | 1 | Temperature warning flag |
| drv_en | output | 5 | Per-output drive enable (0 = floating), OUT1 at bit 0 |
| drv_hi | output | 5 | Per-output level when enabled (1 = high) |
| standby | output | 1 | Standby state indicator |

## Verification
A bus change takes SYNC_STAGES cycles to cross the synchronizer. Session state updates one cycle later and the registered drive outputs one cycle after that, so drive results are due four cycles after a stimulus at the default settings. Diagnostic data and its enable add one more register after the session decode. Every stimulus in the bench is applied on a falling clock edge and held for six cycles before the ports are sampled on a falling edge, which stays clear of that latency. The clear timeout is measured from the synchronized select. The bench therefore holds short pulses 20 cycles below CLR_CYC and long pulses 20 cycles above it, so the synchronizer delay cannot move the result.

// File: rtl/pbus_bridge_pkg.sv
package pbus_bridge_pkg;

   localparam int NIB_W   = 4;
   localparam int NUM_OUT = 5;
   localparam int RET_IDX = 3;            // shared return half-bridge
   localparam int HS_IDX  = 4;            // high-side switch
   localparam int PAGE_W  = 2;
   localparam int DIAG_W  = NUM_OUT + 4;

   typedef enum logic [1:0] {
      SES_IDLE  = 2'd0,
      SES_OPEN  = 2'd1,
      SES_LOCK  = 2'd2,
      SES_SLEEP = 2'd3
   } ses_e;

   typedef struct packed {
      logic [NUM_OUT-1:0] en;
      logic [NUM_OUT-1:0] hi;
      logic [PAGE_W-1:0]  page;
   } cmd_state_t;

   localparam cmd_state_t CMD_CLEARED = '0;

   function automatic cmd_state_t apply_cmd(cmd_state_t cur, logic mode,
                                            logic [NIB_W-1:0] d);
      cmd_state_t nxt;
      nxt = cur;
      if (!mode) begin
         nxt.en[RET_IDX:0] = '0;
         nxt.hi[RET_IDX:0] = '0;
         if (d[3:2] != 2'b11) begin
            case (d[1:0])
               2'b01: begin
                  nxt.en[d[3:2]] = 1'b1;
                  nxt.hi[d[3:2]] = 1'b1;
                  nxt.en[RET_IDX] = 1'b1;
               end
               2'b10: begin
                  nxt.en[d[3:2]] = 1'b1;
                  nxt.en[RET_IDX] = 1'b1;
                  nxt.hi[RET_IDX] = 1'b1;
               end
               2'b11: begin
                  nxt.en[d[3:2]] = 1'b1;
                  nxt.en[RET_IDX] = 1'b1;
               end
               default: ;
            endcase
         end
      end else begin
         case (d[3:2])
            2'b00: begin
               nxt.en[HS_IDX] = d[0];
               nxt.hi[HS_IDX] = d[0];
            end
            2'b01: nxt.page = d[PAGE_W-1:0];
            default: ;
         endcase
      end
      return nxt;
   endfunction

   function automatic logic [NIB_W-1:0] diag_pick(logic [PAGE_W-1:0] page,
                                                  logic [DIAG_W-1:0] v);
      case (page)
         2'd0:    return v[3:0];
         2'd1:    return v[7:4];
         2'd2:    return {3'b000, v[8]};
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pbus_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pbus_session.sv
module pbus_session
   import pbus_bridge_pkg::*;
#(
   parameter int CLR_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n_s,
   input  logic rd_s,
   input  logic cmd_zero,
   output logic wr_open,
   output logic rd_open,
   output logic store_stb,
   output logic clear_stb,
   output logic sleep,
   output logic locked
);

   localparam int CNT_W = (CLR_CYC > 2) ? $clog2(CLR_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_CYC - 1);

   ses_e             state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             sel_prev_n;
   logic             sel_fall;

   assign sel_fall = sel_prev_n & ~sel_n_s;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      store_stb = 1'b0;
      clear_stb = 1'b0;
      case (state_q)
         SES_IDLE, SES_SLEEP: begin
            if (sel_fall) begin
               state_d = SES_OPEN;
               cnt_d   = '0;
            end
         end
         SES_OPEN: begin
            if (sel_n_s) begin
               state_d = SES_IDLE;
               if (!rd_s && cmd_zero) begin
                  state_d   = SES_SLEEP;
                  clear_stb = 1'b1;
               end else if (!rd_s) begin
                  store_stb = 1'b1;
               end
            end else if (cnt_q == CNT_LAST) begin
               state_d   = SES_LOCK;
               clear_stb = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         SES_LOCK: begin
            if (sel_n_s) state_d = SES_IDLE;
         end
         default: state_d = SES_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SES_IDLE;
         cnt_q      <= '0;
         sel_prev_n <= 1'b0;
      end else begin
         state_q    <= state_d;
         cnt_q      <= cnt_d;
         sel_prev_n <= sel_n_s;
      end
   end

   assign wr_open = (state_q == SES_OPEN) && !sel_n_s && !rd_s;
   assign rd_open = (state_q == SES_OPEN) && !sel_n_s &&  rd_s;
   assign sleep   = (state_q == SES_SLEEP);
   assign locked  = (state_q == SES_LOCK);

endmodule

// File: rtl/pbus_cmd_regs.sv
module pbus_cmd_regs
   import pbus_bridge_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_open,
   input  logic               store_stb,
   input  logic               clear_stb,
   input  logic               quiet,
   input  logic               mode_s,
   input  logic [NIB_W-1:0]   data_s,
   output logic [NUM_OUT-1:0] drv_en,
   output logic [NUM_OUT-1:0] drv_hi,
   output logic [PAGE_W-1:0]  page
);

   cmd_state_t stored_q;
   cmd_state_t applied;
   cmd_state_t shown;

   assign applied = apply_cmd(stored_q, mode_s, data_s);

   always_comb begin
      if (clear_stb || quiet)       shown = CMD_CLEARED;
      else if (wr_open || store_stb) shown = applied;
      else                           shown = stored_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stored_q <= CMD_CLEARED;
      else if (clear_stb) stored_q <= CMD_CLEARED;
      else if (store_stb) stored_q <= applied;
   end

   assign page = stored_q.page;

   if (OUT_REG) begin : g_out_reg
      logic [NUM_OUT-1:0] en_q, hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q <= '0;
            hi_q <= '0;
         end else begin
            en_q <= shown.en;
            hi_q <= shown.hi;
         end
      end
      assign drv_en = en_q;
      assign drv_hi = hi_q;
   end else begin : g_out_comb
      assign drv_en = shown.en;
      assign drv_hi = shown.hi;
   end

endmodule

// File: rtl/pbus_bridge_ctrl.sv
module pbus_bridge_ctrl
   import pbus_bridge_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CLR_CYC     = 100,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel_n,
   input  logic               bus_rd_wn,
   input  logic               bus_mode,
   input  logic [NIB_W-1:0]   bus_d_in,
   output logic [NIB_W-1:0]   bus_d_out,
   output logic               bus_d_oe,
   input  logic [NUM_OUT-1:0] out_level,
   input  logic               ovc_bridge,
   input  logic               ovc_hs,
   input  logic               overvolt,
   input  logic               overtemp,
   output logic [NUM_OUT-1:0] drv_en,
   output logic [NUM_OUT-1:0] drv_hi,
   output logic               standby
);

   localparam int BUS_W = NIB_W + 3;

   if (CLR_CYC < 4) begin : g_bad_clr
      $error("pbus_bridge_ctrl: CLR_CYC must be at least 4");
   end

   logic [BUS_W-1:0]  bus_s;
   logic              sel_n_s, rd_s, mode_s;
   logic [NIB_W-1:0]  data_s;
   logic              wr_open, rd_open, store_stb, clear_stb, sleep, locked;
   logic [PAGE_W-1:0] page;
   logic [DIAG_W-1:0] diag_vec;
   logic [NIB_W-1:0]  d_out_q;
   logic              oe_q;

   pbus_sync #(
      .WIDTH   (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ('0)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_sel_n, bus_rd_wn, bus_mode, bus_d_in}),
      .q     (bus_s)
   );

   assign {sel_n_s, rd_s, mode_s, data_s} = bus_s;

   pbus_session #(
      .CLR_CYC (CLR_CYC)
   ) u_session (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n_s   (sel_n_s),
      .rd_s      (rd_s),
      .cmd_zero  (!mode_s && (data_s == '0)),
      .wr_open   (wr_open),
      .rd_open   (rd_open),
      .store_stb (store_stb),
      .clear_stb (clear_stb),
      .sleep     (sleep),
      .locked    (locked)
   );

   pbus_cmd_regs #(
      .OUT_REG (OUT_REG)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_open   (wr_open),
      .store_stb (store_stb),
      .clear_stb (clear_stb),
      .quiet     (sleep || locked),
      .mode_s    (mode_s),
      .data_s    (data_s),
      .drv_en    (drv_en),
      .drv_hi    (drv_hi),
      .page      (page)
   );

   assign diag_vec = {overtemp, overvolt, ovc_hs, ovc_bridge, out_level};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_out_q <= '0;
         oe_q    <= 1'b0;
      end else begin
         d_out_q <= diag_pick(page, diag_vec);
         oe_q    <= rd_open;
      end
   end

   assign bus_d_out = d_out_q;
   assign bus_d_oe  = oe_q;
   assign standby   = sleep;

endmodule

// File: rtl/pbus_bridge_chk.sv
module pbus_bridge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [4:0] drv_en,
   input logic [4:0] drv_hi,
   input logic       bus_d_oe,
   input logic       sel_n_s,
   input logic       rd_s,
   input logic       rd_open,
   input logic       sleep,
   input logic       locked
);

   // R3: a single bridge among OUT1..OUT3
   a_r3_one_bridge: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(drv_en[2:0]) <= 1);

   // R3: the return half-bridge is on exactly when a bridge leg is on
   a_r3_return_paired: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en[3] == (|drv_en[2:0]));

   // R6: pads driven only after a selected read
   a_r6_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
      bus_d_oe |-> $past(!sel_n_s && rd_s));

   // R7: drives hold through a read
   a_r7_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      rd_open && $past(rd_open) && $past(rd_open, 2)
      |-> $stable(drv_en) && $stable(drv_hi));

   // R8: lockout keeps everything floating
   a_r8_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      locked && $past(locked) |-> (drv_en == 5'b0) && !bus_d_oe);

   // R9: standby keeps everything floating
   a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      sleep && $past(sleep) |-> (drv_en == 5'b0) && !bus_d_oe);

endmodule

bind pbus_bridge_ctrl pbus_bridge_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .drv_en   (drv_en),
   .drv_hi   (drv_hi),
   .bus_d_oe (bus_d_oe),
   .sel_n_s  (sel_n_s),
   .rd_s     (rd_s),
   .rd_open  (rd_open),
   .sleep    (sleep),
   .locked   (locked)
);

// File: tb/pbus_bridge_ctrl_test.sv
`timescale 1ns/1ps
module pbus_bridge_ctrl_test;

   localparam int CLR = 100;
   localparam int GAP = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b1, rd_wn = 1'b0, mode = 1'b0;
   logic [3:0] d_in = 4'h0;
   logic [3:0] d_out;
   logic       d_oe;
   logic [4:0] level = 5'b0;
   logic       ovc_br = 1'b0, ovc_h = 1'b0, ovv = 1'b0, otemp = 1'b0;
   logic [4:0] en, hi;
   logic       stby;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pbus_bridge_ctrl #(.SYNC_STAGES(2), .CLR_CYC(CLR), .OUT_REG(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_rd_wn(rd_wn),
      .bus_mode(mode), .bus_d_in(d_in), .bus_d_out(d_out), .bus_d_oe(d_oe),
      .out_level(level), .ovc_bridge(ovc_br), .ovc_hs(ovc_h),
      .overvolt(ovv), .overtemp(otemp), .drv_en(en), .drv_hi(hi),
      .standby(stby)
   );

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_eq(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic expect_drv(string tag, logic [4:0] e_en, logic [4:0] e_hi);
      expect_eq(tag, "drv_en", int'(en), int'(e_en));
      expect_eq(tag, "drv_hi", int'(hi), int'(e_hi));
   endtask

   task automatic wr_cmd(logic m, logic [3:0] dv);
      rd_wn = 1'b0; mode = m; d_in = dv;
      cyc(2);
      sel_n = 1'b0;
      cyc(GAP);
      sel_n = 1'b1;
      cyc(GAP);
   endtask

   task automatic t_reset;
      cyc(GAP);
      expect_eq("R1", "drv_en", int'(en), 0);
      expect_eq("R1", "bus_d_oe", int'(d_oe), 0);
      expect_eq("R1", "standby", int'(stby), 0);
   endtask

   task automatic t_transparent;
      rd_wn = 1'b0; mode = 1'b0; d_in = 4'b0001;
      cyc(2);
      sel_n = 1'b0;
      cyc(GAP);
      expect_drv("R2", 5'b01001, 5'b00001);
      d_in = 4'b0010;
      cyc(GAP);
      expect_drv("R2", 5'b01001, 5'b01000);
      sel_n = 1'b1;
      cyc(GAP);
      expect_drv("R5", 5'b01001, 5'b01000);
      d_in = 4'b0101; mode = 1'b1;
      cyc(GAP);
      rd_wn = 1'b1;
      cyc(GAP);
      expect_drv("R6", 5'b01001, 5'b01000);
      expect_eq("R6", "bus_d_oe", int'(d_oe), 0);
   endtask

   task automatic t_commands;
      wr_cmd(1'b1, 4'b0001);
      expect_drv("R4", 5'b11001, 5'b11000);
      wr_cmd(1'b0, 4'b1011);
      expect_drv("R3", 5'b11100, 5'b10000);
      wr_cmd(1'b0, 4'b1101);
      expect_drv("R3", 5'b10000, 5'b10000);
      wr_cmd(1'b1, 4'b1001);
      expect_drv("R4", 5'b10000, 5'b10000);
      wr_cmd(1'b0, 4'b0101);
      expect_drv("R3", 5'b11010, 5'b10010);
      wr_cmd(1'b1, 4'b0000);
      expect_drv("R4", 5'b01010, 5'b00010);
      wr_cmd(1'b0, 4'b0110);
      expect_drv("R3", 5'b01010, 5'b01000);
   endtask

   task automatic rd_page(logic [1:0] pg, logic [3:0] exp);
      wr_cmd(1'b1, {2'b01, pg});
      rd_wn = 1'b1;
      cyc(2);
      sel_n = 1'b0;
      cyc(GAP);
      expect_eq("R7", "bus_d_oe", int'(d_oe), 1);
      expect_eq("R7", "bus_d_out", int'(d_out), int'(exp));
      expect_drv("R7", 5'b01010, 5'b01000);
      sel_n = 1'b1;
      cyc(GAP);
      expect_eq("R7", "bus_d_oe", int'(d_oe), 0);
   endtask

   task automatic t_read;
      level = 5'b10110; ovc_br = 1'b1; ovc_h = 1'b0; ovv = 1'b1; otemp = 1'b1;
      rd_page(2'd0, 4'b0110);
      rd_page(2'd1, 4'b1011);
      rd_page(2'd2, 4'b0001);
      rd_page(2'd3, 4'b0000);
   endtask

   task automatic t_timeout;
      wr_cmd(1'b1, 4'b0001);
      expect_drv("R4", 5'b11010, 5'b11000);
      rd_wn = 1'b0; mode = 1'b0; d_in = 4'b1001;
      cyc(2);
      sel_n = 1'b0;
      cyc(CLR - 20);
      expect_drv("R8", 5'b11100, 5'b10100);
      sel_n = 1'b1;
      cyc(GAP);
      expect_drv("R8", 5'b11100, 5'b10100);
      d_in = 4'b0001;
      cyc(2);
      sel_n = 1'b0;
      cyc(CLR + 20);
      expect_drv("R8", 5'b00000, 5'b00000);
      d_in = 4'b1001;
      cyc(GAP);
      expect_drv("R8", 5'b00000, 5'b00000);
      sel_n = 1'b1;
      cyc(GAP);
      expect_drv("R8", 5'b00000, 5'b00000);
      rd_wn = 1'b1;
      cyc(2);
      sel_n = 1'b0;
      cyc(GAP);
      expect_eq("R8", "page after clear", int'(d_out), 4'b0110);
      sel_n = 1'b1;
      cyc(GAP);
      wr_cmd(1'b0, 4'b0001);
      expect_drv("R8", 5'b01001, 5'b00001);
   endtask

   task automatic t_standby;
      wr_cmd(1'b1, 4'b0001);
      expect_drv("R9", 5'b11001, 5'b10001);
      wr_cmd(1'b0, 4'b0000);
      expect_eq("R9", "standby", int'(stby), 1);
      expect_drv("R9", 5'b00000, 5'b00000);
      rd_wn = 1'b1;
      cyc(2);
      sel_n = 1'b0;
      cyc(GAP);
      expect_eq("R10", "standby", int'(stby), 0);
      expect_eq("R10", "bus_d_oe", int'(d_oe), 1);
      expect_drv("R10", 5'b00000, 5'b00000);
      rd_wn = 1'b1; mode = 1'b0; d_in = 4'b0000;
      sel_n = 1'b1;
      cyc(GAP);
      expect_eq("R9", "standby on read release", int'(stby), 0);
      expect_drv("R10", 5'b00000, 5'b00000);
   endtask

   initial begin
      cyc(4);
      rst_n = 1'b1;
      t_reset();
      t_transparent();
      t_commands();
      t_read();
      t_timeout();
      t_standby();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule